// File: doc/BRIEF.md
# Fast Interrupt Fetch Injector

This block drives the fetch address of a three-stage (fetch, decode, execute) program controller and splices interrupt service into that stream. A request arrives with an interrupt number. It is registered once as synchronized, then held as pending. At the next legal fetch slot, the sequencer fetches the two words at vector address `2*num` and `2*num+1` in place of two sequential fetches. It then resumes at the program counter it had not yet used. No context is saved and no return instruction is needed.

Every fetch slot carries a valid flag, an interrupt flag and a tag holding the interrupt number. These travel with the slot into the decode stage and the execute stage. If an injected word carries the subroutine-call opcode, the service becomes a long interrupt: fetching continues at the call target, any unfetched vector word is skipped, and `long_interrupt` pulses. A repeat word and the word after it are kept together. Fetching then pauses while the repeat count runs out.

Top module: `fast_irq_injector`

## Requirements
- R1: During and straight after reset, `fetch_addr` equals `RESET_PC` (default 16'h0040), `fetch_valid` is 1, and `fetch_is_irq`, `long_interrupt`, `dec_valid` and `exe_valid` are 0.
- R2: A request that is high at clock edge k is taken into a synchronizing register and becomes pending at edge k+1. Its first vector word is fetched no earlier than the cycle after edge k+1. A request made while another is still synchronizing or pending is dropped.
- R3: A fast interrupt occupies two consecutive valid slots, at addresses `2*num` then `2*num+1`. Both have `fetch_is_irq`=1 and `fetch_tag`=num.
- R4: After a fast interrupt, the next normal slot fetches the program counter that was next in line before the injection. Normal slots otherwise count up by one, with `fetch_tag`=0.
- R5: No injection starts during an injection. After the last slot of any interrupt, at least LOCK_N (default 2) valid normal slots pass before the next injection starts.
- R6: If the first vector word has opcode field [23:16] equal to CALL_OP (8'hD0), the second vector word is not fetched. The next slot is normal, at the target in bits [15:0].
- R7: If only the second vector word is a call, both words are fetched and the next slot is normal at that word's target in bits [15:0].
- R8: A normal word with opcode field [23:16] equal to REP_OP (8'h06) is always followed by a normal slot for the next word. Then `fetch_valid` is 0 for C cycles, where C is bits [7:0] of the repeat word. No injection takes place during that time.
- R9: `dec_valid`/`dec_is_irq`/`dec_tag` repeat the fetch slot one cycle later, and `exe_valid`/`exe_is_irq`/`exe_tag` repeat it two cycles later.
- R10: `long_interrupt` is high for exactly the one cycle after a call word is fetched in an interrupt slot, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Interrupt request, sampled each edge |
| irq_num | input | NUM_W | Number of the requesting interrupt |
| fetch_data | input | WORD_W | Word stored at `fetch_addr` in the same cycle |
| fetch_addr | output | ADDR_W | Address fetched in this slot |
| fetch_valid | output | 1 | Slot holds a fetch (low while a repeat runs) |
| fetch_is_irq | output | 1 | Slot holds a vector word |
| fetch_tag | output | NUM_W | Interrupt number of a vector slot, else 0 |
| dec_valid | output | 1 | Decode-stage slot valid |
| dec_is_irq | output | 1 | Decode-stage slot is a vector word |
| dec_tag | output | NUM_W | Decode-stage tag |
| exe_valid | output | 1 | Execute-stage slot valid |
| exe_is_irq | output | 1 | Execute-stage slot is a vector word |
| exe_tag | output | NUM_W | Execute-stage tag |
| long_interrupt | output | 1 | Pulse marking a call taken from a vector word |

## Verification
A pending request can become eligible in the very cycle that the word after a repeat is fetched, or in the cycle that the lockout after an interrupt runs out. The injection must then be held back in the first case and granted at once in the second. The bench provokes both with requests held high for several cycles at many offsets, as the normal stream passes repeat words and as interrupts follow one another. A behavioural model computes the expected slot every cycle, and an independent monitor counts the normal slots between interrupt groups.

// File: rtl/fii_pkg.sv
package fii_pkg;
   typedef enum logic {
      ST_NORM = 1'b0,
      ST_VEC2 = 1'b1
   } seq_st_e;
endpackage

// File: rtl/fii_sync.sv
module fii_sync #(
   parameter int NUM_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [NUM_W-1:0] req_num,
   input  logic             take,
   output logic             pend_v,
   output logic [NUM_W-1:0] pend_num
);
   logic             sync_v;
   logic [NUM_W-1:0] sync_num;
   logic             accept;

   assign accept = req && !sync_v && !pend_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_v   <= 1'b0;
         sync_num <= '0;
         pend_v   <= 1'b0;
         pend_num <= '0;
      end else begin
         sync_v <= accept;
         if (accept) sync_num <= req_num;
         if (sync_v) begin
            pend_v   <= 1'b1;
            pend_num <= sync_num;
         end else if (take) begin
            pend_v <= 1'b0;
         end
      end
   end

   // R2: pending only ever follows a synchronized cycle
   a_r2_pend_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_v) |-> $past(sync_v));

   // R2: a second request never sits beside a held one
   a_r2_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(sync_v && pend_v));
endmodule

// File: rtl/fii_seq.sv
module fii_seq
   import fii_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 24,
   parameter int OP_W = 8,
   parameter int NUM_W = 3,
   parameter int CNT_W = 8,
   parameter int LOCK_N = 2,
   parameter logic [OP_W-1:0] CALL_OP = 8'hD0,
   parameter logic [OP_W-1:0] REP_OP = 8'h06,
   parameter logic [ADDR_W-1:0] RESET_PC = 16'h0040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend_v,
   input  logic [NUM_W-1:0]  pend_num,
   input  logic [WORD_W-1:0] fetch_data,
   output logic              take,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_valid,
   output logic              fetch_is_irq,
   output logic [NUM_W-1:0]  fetch_tag,
   output logic              long_interrupt
);
   localparam int LOCK_W = $clog2(LOCK_N + 2);
   localparam logic [LOCK_W-1:0] LOCK_INIT = LOCK_W'(LOCK_N);

   seq_st_e           st_q;
   logic [ADDR_W-1:0] pc_q, vec2_q, vbase, target;
   logic [LOCK_W-1:0] lock_q;
   logic              rep_follow_q;
   logic [CNT_W-1:0]  rep_cnt_q, stall_q, cnt;
   logic [NUM_W-1:0]  cur_q;
   logic              long_q;
   logic [OP_W-1:0]   opcode;
   logic              is_call, is_rep, stalled, inj, irq_slot;

   always_comb begin
      vbase = '0;
      vbase[NUM_W:0] = {pend_num, 1'b0};
   end

   assign opcode   = fetch_data[WORD_W-1 -: OP_W];
   assign target   = fetch_data[ADDR_W-1:0];
   assign cnt      = fetch_data[CNT_W-1:0];
   assign is_call  = (opcode == CALL_OP);
   assign is_rep   = (opcode == REP_OP);
   assign stalled  = (stall_q != '0);
   assign inj      = pend_v && (st_q == ST_NORM) && (lock_q == '0)
                     && !rep_follow_q && !stalled;
   assign irq_slot = inj || (st_q == ST_VEC2);

   assign take           = inj;
   assign fetch_valid    = !stalled;
   assign fetch_is_irq   = irq_slot;
   assign fetch_tag      = inj ? pend_num : ((st_q == ST_VEC2) ? cur_q : '0);
   assign fetch_addr     = inj ? vbase : ((st_q == ST_VEC2) ? vec2_q : pc_q);
   assign long_interrupt = long_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_NORM;
         pc_q         <= RESET_PC;
         vec2_q       <= '0;
         lock_q       <= '0;
         rep_follow_q <= 1'b0;
         rep_cnt_q    <= '0;
         stall_q      <= '0;
         cur_q        <= '0;
         long_q       <= 1'b0;
      end else begin
         long_q <= irq_slot && is_call;
         if (stalled) begin
            stall_q <= stall_q - CNT_W'(1);
         end else if (inj) begin
            cur_q  <= pend_num;
            lock_q <= LOCK_INIT;
            if (is_call) begin
               pc_q <= target;
            end else begin
               st_q   <= ST_VEC2;
               vec2_q <= vbase + ADDR_W'(1);
            end
         end else if (st_q == ST_VEC2) begin
            st_q   <= ST_NORM;
            lock_q <= LOCK_INIT;
            if (is_call) pc_q <= target;
         end else begin
            pc_q <= pc_q + ADDR_W'(1);
            if (lock_q != '0) lock_q <= lock_q - LOCK_W'(1);
            if (rep_follow_q) begin
               rep_follow_q <= 1'b0;
               stall_q      <= rep_cnt_q;
            end else if (is_rep) begin
               rep_follow_q <= 1'b1;
               rep_cnt_q    <= cnt;
            end
         end
      end
   end

   // Checker support: normal slots seen since the last vector slot
   logic [LOCK_W-1:0] norm_seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) norm_seen_q <= LOCK_INIT;
      else if (fetch_valid && fetch_is_irq) norm_seen_q <= '0;
      else if (fetch_valid && norm_seen_q != LOCK_INIT) norm_seen_q <= norm_seen_q + LOCK_W'(1);
   end

   // R5
   a_r5_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (norm_seen_q == LOCK_INIT));

   // R3
   a_r3_second_word: assert property (@(posedge clk) disable iff (!rst_n)
      $past(take && !is_call) |-> (fetch_is_irq && fetch_addr == $past(fetch_addr) + ADDR_W'(1)));

   // R6
   a_r6_skip_second: assert property (@(posedge clk) disable iff (!rst_n)
      $past(take && is_call) |-> (!fetch_is_irq && fetch_addr == $past(target)));

   // R8
   a_r8_stall_after_normal: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fetch_valid) |-> $past(!fetch_is_irq));

   // R10
   a_r10_long_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      long_interrupt |=> !long_interrupt);
endmodule

// File: rtl/fii_pipe.sv
module fii_pipe #(
   parameter int TAG_W = 3,
   parameter int STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_v,
   input  logic                         in_irq,
   input  logic [TAG_W-1:0]             in_tag,
   output logic [STAGES-1:0]            out_v,
   output logic [STAGES-1:0]            out_irq,
   output logic [STAGES-1:0][TAG_W-1:0] out_tag
);
   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      logic             v_q, irq_q;
      logic [TAG_W-1:0] tag_q;
      logic             v_d, irq_d;
      logic [TAG_W-1:0] tag_d;

      if (s == 0) begin : g_head
         assign v_d   = in_v;
         assign irq_d = in_irq;
         assign tag_d = in_tag;
      end else begin : g_tail
         assign v_d   = g_stg[s-1].v_q;
         assign irq_d = g_stg[s-1].irq_q;
         assign tag_d = g_stg[s-1].tag_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q   <= 1'b0;
            irq_q <= 1'b0;
            tag_q <= '0;
         end else begin
            v_q   <= v_d;
            irq_q <= irq_d;
            tag_q <= tag_d;
         end
      end

      assign out_v[s]   = v_q;
      assign out_irq[s] = irq_q;
      assign out_tag[s] = tag_q;

      // R9: a vector mark never rides on an empty stage
      a_r9_irq_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
         out_irq[s] |-> out_v[s]);
   end
endmodule

// File: rtl/fast_irq_injector.sv
module fast_irq_injector #(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 24,
   parameter int OP_W = 8,
   parameter int NUM_W = 3,
   parameter int CNT_W = 8,
   parameter int LOCK_N = 2,
   parameter logic [OP_W-1:0] CALL_OP = 8'hD0,
   parameter logic [OP_W-1:0] REP_OP = 8'h06,
   parameter logic [ADDR_W-1:0] RESET_PC = 16'h0040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic [NUM_W-1:0]  irq_num,
   input  logic [WORD_W-1:0] fetch_data,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_valid,
   output logic              fetch_is_irq,
   output logic [NUM_W-1:0]  fetch_tag,
   output logic              dec_valid,
   output logic              dec_is_irq,
   output logic [NUM_W-1:0]  dec_tag,
   output logic              exe_valid,
   output logic              exe_is_irq,
   output logic [NUM_W-1:0]  exe_tag,
   output logic              long_interrupt
);
   localparam int PIPE_N = 2;

   if (NUM_W + 1 > ADDR_W) begin : g_bad_vec
      $error("vector table does not fit the address width");
   end
   if (OP_W + ADDR_W > WORD_W || CNT_W > WORD_W - OP_W) begin : g_bad_word
      $error("opcode and operand fields overlap");
   end

   logic                            pend_v, take;
   logic [NUM_W-1:0]                pend_num;
   logic [PIPE_N-1:0]               p_v, p_irq;
   logic [PIPE_N-1:0][NUM_W-1:0]    p_tag;

   fii_sync #(.NUM_W(NUM_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .req(irq_req), .req_num(irq_num),
      .take(take), .pend_v(pend_v), .pend_num(pend_num)
   );

   fii_seq #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .OP_W(OP_W), .NUM_W(NUM_W),
      .CNT_W(CNT_W), .LOCK_N(LOCK_N), .CALL_OP(CALL_OP), .REP_OP(REP_OP),
      .RESET_PC(RESET_PC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .pend_v(pend_v), .pend_num(pend_num),
      .fetch_data(fetch_data), .take(take), .fetch_addr(fetch_addr),
      .fetch_valid(fetch_valid), .fetch_is_irq(fetch_is_irq),
      .fetch_tag(fetch_tag), .long_interrupt(long_interrupt)
   );

   fii_pipe #(.TAG_W(NUM_W), .STAGES(PIPE_N)) u_pipe (
      .clk(clk), .rst_n(rst_n), .in_v(fetch_valid), .in_irq(fetch_is_irq),
      .in_tag(fetch_tag), .out_v(p_v), .out_irq(p_irq), .out_tag(p_tag)
   );

   assign dec_valid  = p_v[0];
   assign dec_is_irq = p_irq[0];
   assign dec_tag    = p_tag[0];
   assign exe_valid  = p_v[1];
   assign exe_is_irq = p_irq[1];
   assign exe_tag    = p_tag[1];
endmodule

// File: tb/fast_irq_injector_bench.sv
module fast_irq_injector_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [2:0]  irq_num = '0;
   logic [23:0] fetch_data;
   logic [15:0] fetch_addr;
   logic        fetch_valid, fetch_is_irq, dec_valid, dec_is_irq, exe_valid, exe_is_irq;
   logic [2:0]  fetch_tag, dec_tag, exe_tag;
   logic        long_interrupt;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 0;

   always #10 clk = ~clk;

   function automatic logic [23:0] memw(input logic [15:0] a);
      if (a == 16'd4) return {8'hD0, 16'h0100};
      if (a == 16'd7) return {8'hD0, 16'h0200};
      if (a[5:0] == 6'h2A) return {8'h06, 16'h0003};
      if (a[5:0] == 6'h35) return {8'h06, 16'h0000};
      return {8'h01, a};
   endfunction

   assign fetch_data = memw(fetch_addr);

   fast_irq_injector u_fast_irq_injector (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
      .fetch_data(fetch_data), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
      .fetch_is_irq(fetch_is_irq), .fetch_tag(fetch_tag), .dec_valid(dec_valid),
      .dec_is_irq(dec_is_irq), .dec_tag(dec_tag), .exe_valid(exe_valid),
      .exe_is_irq(exe_is_irq), .exe_tag(exe_tag), .long_interrupt(long_interrupt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference
   int m_pc, m_v2addr, m_nsince, m_rcnt, m_stall, m_snum, m_pnum, m_cur;
   bit m_vec2, m_rfollow, m_sv, m_pv, m_long;
   bit m_dv, m_di, m_ev, m_ei;
   int m_dt, m_et;
   bit o_fv, o_inj, o_irq;
   int o_addr, o_tag;

   task automatic m_reset();
      m_pc = 'h40; m_vec2 = 0; m_v2addr = 0; m_nsince = 2; m_rfollow = 0;
      m_rcnt = 0; m_stall = 0; m_sv = 0; m_snum = 0; m_pv = 0; m_pnum = 0;
      m_cur = 0; m_long = 0; m_dv = 0; m_di = 0; m_dt = 0; m_ev = 0; m_ei = 0; m_et = 0;
   endtask

   task automatic m_eval();
      o_fv   = (m_stall == 0);
      o_inj  = o_fv && !m_vec2 && m_pv && (m_nsince >= 2) && !m_rfollow;
      o_irq  = o_inj || m_vec2;
      o_addr = o_inj ? 2 * m_pnum : (m_vec2 ? m_v2addr : m_pc);
      o_tag  = o_inj ? m_pnum : (m_vec2 ? m_cur : 0);
   endtask

   task automatic m_step(input bit req, input int num);
      logic [23:0] w;
      bit call, acc;
      m_eval();
      w = memw(o_addr[15:0]);
      call = (w[23:16] == 8'hD0);
      m_ev = m_dv; m_ei = m_di; m_et = m_dt;
      m_dv = o_fv; m_di = o_irq; m_dt = o_tag;
      m_long = o_irq && call;
      if (!o_fv) m_stall--;
      else if (o_irq) begin
         m_nsince = 0;
         if (o_inj) begin
            m_cur = m_pnum;
            if (call) m_pc = w[15:0];
            else begin m_vec2 = 1; m_v2addr = o_addr + 1; end
         end else begin
            m_vec2 = 0;
            if (call) m_pc = w[15:0];
         end
      end else begin
         m_pc++;
         if (m_nsince < 2) m_nsince++;
         if (m_rfollow) begin m_rfollow = 0; m_stall = m_rcnt; end
         else if (w[23:16] == 8'h06) begin m_rfollow = 1; m_rcnt = w[7:0]; end
      end
      acc = req && !m_sv && !m_pv;
      if (m_sv) begin m_pv = 1; m_pnum = m_snum; end
      else if (o_inj) m_pv = 0;
      m_sv = acc;
      if (acc) m_snum = num;
   endtask

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else m_step(irq_req, int'(irq_num));
   end

   // compare every cycle, plus an independent gap monitor
   bit mon_prev_irq = 0, mon_seen = 0;
   int mon_norm = 0;
   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) begin
         m_eval();
         chk(fetch_valid == o_fv && fetch_is_irq == o_irq &&
             (!o_fv || int'(fetch_addr) == o_addr) && int'(fetch_tag) == o_tag,
             "R2/R3/R4/R8 fetch slot", {fetch_valid, fetch_is_irq, fetch_tag, fetch_addr},
             {o_fv, o_irq, o_tag[2:0], o_addr[15:0]});
         chk(long_interrupt == m_long, "R6/R7/R10 long_interrupt", long_interrupt, m_long);
         chk(dec_valid == m_dv && dec_is_irq == m_di && int'(dec_tag) == m_dt,
             "R9 decode stage", {dec_valid, dec_is_irq, dec_tag}, {m_dv, m_di, m_dt[2:0]});
         chk(exe_valid == m_ev && exe_is_irq == m_ei && int'(exe_tag) == m_et,
             "R9 execute stage", {exe_valid, exe_is_irq, exe_tag}, {m_ev, m_ei, m_et[2:0]});
         if (fetch_valid) begin
            if (fetch_is_irq && !mon_prev_irq) begin
               if (mon_seen) chk(mon_norm >= 2, "R5 normal slots between interrupts", mon_norm, 2);
               mon_seen = 1;
               mon_norm = 0;
            end else if (!fetch_is_irq) mon_norm++;
            mon_prev_irq = fetch_is_irq;
         end
      end
   end

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      finish_run();
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hold_req(input int num, input int n);
      @(negedge clk);
      irq_req = 1'b1;
      irq_num = 3'(num);
      repeat (n) @(negedge clk);
      irq_req = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(fetch_addr == 16'h0040, "R1 reset fetch_addr", fetch_addr, 'h40);
      chk(fetch_valid == 1'b1, "R1 reset fetch_valid", fetch_valid, 1);
      chk(fetch_is_irq == 1'b0 && long_interrupt == 1'b0, "R1 reset flags",
          {fetch_is_irq, long_interrupt}, 0);
      chk(dec_valid == 1'b0 && exe_valid == 1'b0, "R1 reset pipeline", {dec_valid, exe_valid}, 0);
      rst_n = 1'b1;
      idle(4);
      hold_req(1, 1);       // R3/R4 plain fast interrupt
      idle(12);
      hold_req(5, 2);       // R2 second pulse cycle dropped
      idle(12);
      hold_req(1, 1);       // R5 back to back: held request waits for lockout
      hold_req(6, 8);
      idle(12);
      hold_req(2, 1);       // R6 call in first word
      idle(12);
      hold_req(3, 1);       // R7 call in second word
      idle(12);
      for (int i = 0; i < 500; i++) begin   // R8 and mixed collisions
         @(negedge clk);
         irq_req = ((i % 11) < 4) || ((i % 17) == 9);
         irq_num = 3'((i / 11) % 8);
      end
      irq_req = 1'b0;
      idle(20);
      finish_run();
   end
endmodule